// File: doc/BRIEF.md
# Two-Channel Auxiliary Pulse-Width Generator

This block drives two pulse-width modulated outputs from a shared time base that advances once every two system clocks. Each channel has a 16-bit period word and a 16-bit on-time word. A period word of P gives a cycle of P + 1 ticks. An on-time word of O keeps the output high for the first O ticks of each cycle. The output is therefore high for 2·O clocks out of 2·(P + 1), anywhere from fully low to fully high.

A mode input picks one of two arrangements. In independent mode each channel counts its own period. In offset mode both channels run on channel 0's period, and channel 1's period word is used as a phase delay: channel 1's cycle starts that many ticks after channel 0's. Register words are copied into shadow copies only at a period boundary, or continuously while the block is disabled, so a write never cuts a pulse short in mid-cycle. Typical uses are gate drive for auxiliary power stages or, with an outside low-pass filter, a one-bit DAC.

Top module: `aux_pwm_pair`

## Requirements
- R1: While `en` is 0 both outputs are 0 and both channel counters are held at tick 0. Raising `en` starts both channels at tick 0 of a fresh cycle, using the register values present on the clock before.
- R2: The time base advances one tick every 2 clocks. In independent mode channel c has a cycle of (`period_c` + 1) ticks.
- R3: Ticks are numbered from 0 within a cycle. An output is 1 during ticks whose index is below its active on-time word and 0 otherwise, so it is high for 2·`on_time_c` clocks per cycle.
- R4: An on-time word of 0 keeps the output at 0 for the whole cycle.
- R5: An on-time word larger than the active period word keeps the output at 1 for the whole cycle. This includes a period word of 0 with an on-time word of 1.
- R6: In offset mode channel 1 uses channel 0's period P0, takes its duty from `on_time1`, and follows phase (t − D) mod (P0 + 1), where t is channel 0's tick index and D is `period1`.
- R7: In offset mode a delay word D larger than P0 acts as D = P0.
- R8: A change to a channel's period or on-time word takes effect only at that channel's next cycle start. In offset mode channel 1's words take effect at channel 0's cycle start.
- R9: `indep_mode` = 1 selects independent mode and 0 selects offset mode. The value is captured while disabled and at channel 0's cycle start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; 0 forces outputs low and counters to zero |
| indep_mode | input | 1 | 1 = independent channels, 0 = offset mode |
| period0 | input | 16 | Channel 0 period word (cycle = word + 1 ticks) |
| period1 | input | 16 | Channel 1 period word, or the phase delay in offset mode |
| on_time0 | input | 16 | Channel 0 on-time in ticks |
| on_time1 | input | 16 | Channel 1 on-time in ticks |
| pwm0 | output | 1 | Channel 0 pulse output |
| pwm1 | output | 1 | Channel 1 pulse output |

## Verification
The bench targets the duty extremes. With on-time 0 a design off by one would emit a one-tick sliver. With on-time one above the period, or period 0 with on-time 1, a compare written with the wrong inequality would drop low for a tick. In offset mode it covers delays of zero, a delay inside the period and a delay beyond the period: a missing clamp would shift the phase by the wrong amount, and a bad wrap-around would put a hole in channel 1's pulse. Writes in mid-cycle and a mode switch in mid-run are timed so that a design loading its shadow words early would change the pulse width inside the current cycle and miscompare. Disabling and re-enabling checks that a design which failed to clear its counters would restart at the wrong phase.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

  typedef enum logic {
    MODE_OFFSET = 1'b0,
    MODE_INDEP  = 1'b1
  } aux_mode_e;

endpackage

// File: rtl/aux_pwm_prescale.sv
module aux_pwm_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick = en && (pre_q == LAST);

  always_comb begin
    if (!en || tick) pre_d = '0;
    else             pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/aux_pwm_chan_cnt.sv
module aux_pwm_chan_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         run,
  input  logic         tick,
  input  logic         load_req,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] on_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_q,
  output logic [W-1:0] on_q,
  output logic         wrap
);
  logic [W-1:0] cnt_d, per_d, on_d;
  logic         shadow_ld;

  assign wrap      = run && tick && (cnt == per_q);
  assign shadow_ld = !en || load_req;

  always_comb begin
    if (!run)       cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else if (tick)  cnt_d = cnt + W'(1);
    else            cnt_d = cnt;
    per_d = shadow_ld ? per_in : per_q;
    on_d  = shadow_ld ? on_in  : on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_q <= '0;
      on_q  <= '0;
    end else begin
      cnt   <= cnt_d;
      per_q <= per_d;
      on_q  <= on_d;
    end
  end
endmodule

// File: rtl/aux_pwm_cmp.sv
module aux_pwm_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] span,
  input  logic [W-1:0] delay,
  input  logic [W-1:0] on_val,
  input  logic         shift_en,
  output logic         hit
);
  localparam int XW = W + 1;

  logic [W-1:0]  d_eff;
  logic [XW-1:0] phase;

  always_comb begin
    d_eff = (delay > span) ? span : delay;
    if (!shift_en)
      phase = {1'b0, cnt};
    else if (cnt >= d_eff)
      phase = {1'b0, cnt} - {1'b0, d_eff};
    else
      phase = {1'b0, cnt} + {1'b0, span} + XW'(1) - {1'b0, d_eff};
    hit = phase < {1'b0, on_val};
  end
endmodule

// File: rtl/aux_pwm_pair.sv
module aux_pwm_pair
  import aux_pwm_pkg::*;
#(
  parameter int W        = 16,
  parameter int TICK_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         indep_mode,
  input  logic [W-1:0] period0,
  input  logic [W-1:0] period1,
  input  logic [W-1:0] on_time0,
  input  logic [W-1:0] on_time1,
  output logic         pwm0,
  output logic         pwm1
);
  localparam int NCH = 2;

  logic                  tick;
  aux_mode_e             mode_q, mode_d, mode_in;
  logic [NCH-1:0][W-1:0] per_in, on_in, cnt, per_q, on_q;
  logic [NCH-1:0]        wrap, run, load_req;
  logic [W-1:0]          cnt1_sel;
  logic                  hit0, hit1, mode_is_indep;

  assign per_in        = {period1, period0};
  assign on_in         = {on_time1, on_time0};
  assign mode_in       = aux_mode_e'(indep_mode);
  assign mode_is_indep = (mode_q == MODE_INDEP);

  aux_pwm_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  always_comb begin
    run[0]      = en;
    run[1]      = en && mode_is_indep;
    load_req[0] = wrap[0];
    load_req[1] = wrap[1] ||
                  (wrap[0] && (!mode_is_indep || (mode_in == MODE_OFFSET)));
    mode_d      = (!en || wrap[0]) ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFFSET;
    else        mode_q <= mode_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    aux_pwm_chan_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .run(run[g]), .tick(tick),
      .load_req(load_req[g]), .per_in(per_in[g]), .on_in(on_in[g]),
      .cnt(cnt[g]), .per_q(per_q[g]), .on_q(on_q[g]), .wrap(wrap[g])
    );
  end

  assign cnt1_sel = mode_is_indep ? cnt[1] : cnt[0];

  aux_pwm_cmp #(.W(W)) u_cmp0 (
    .cnt(cnt[0]), .span(per_q[0]), .delay('0), .on_val(on_q[0]),
    .shift_en(1'b0), .hit(hit0)
  );

  aux_pwm_cmp #(.W(W)) u_cmp1 (
    .cnt(cnt1_sel), .span(per_q[0]), .delay(per_q[1]), .on_val(on_q[1]),
    .shift_en(!mode_is_indep), .hit(hit1)
  );

  assign pwm0 = en && hit0;
  assign pwm1 = en && hit1;
endmodule

// File: rtl/aux_pwm_pair_chk.sv
module aux_pwm_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         tick,
  input logic         wrap0,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] per_q0,
  input logic [W-1:0] on_q0,
  input logic         pwm0
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt0 == '0) && (cnt1 == '0));

  p_tick_pace_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt0 <= per_q0);

  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap0 |=> cnt0 == '0);

  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q0 == '0) |-> !pwm0);

  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (on_q0 > per_q0)) |-> pwm0);

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(wrap0)) |-> ($stable(per_q0) && $stable(on_q0)));
endmodule

bind aux_pwm_pair aux_pwm_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wrap0(wrap[0]),
  .cnt0(cnt[0]), .cnt1(cnt[1]), .per_q0(per_q[0]), .on_q0(on_q[0]),
  .pwm0(pwm0)
);

// File: tb/aux_pwm_pair_tb.sv
module aux_pwm_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk, rst_n, en, indep_mode, pwm0, pwm1;
  logic [W-1:0] period0, period1, on_time0, on_time1;
  int n_vec, n_bad, k;
  bit done;

  aux_pwm_pair #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .indep_mode(indep_mode),
    .period0(period0), .period1(period1), .on_time0(on_time0),
    .on_time1(on_time1), .pwm0(pwm0), .pwm1(pwm1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit f_lin(int kk, int p, int o);
    return ((kk / 2) % (p + 1)) < o;
  endfunction

  function automatic bit f_off(int kk, int p, int d, int o);
    int dc = (d > p) ? p : d;
    int ph = (kk / 2) % (p + 1);
    ph = (ph + (p + 1) - dc) % (p + 1);
    return ph < o;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s k=%0d actual=%0b expected=%0b", req, what, k, act, exp);
    end
  endtask

  task automatic start(input int p0, input int o0, input int p1, input int o1, input bit md);
    @(negedge clk);
    en = 1'b0; indep_mode = md;
    period0 = W'(p0); on_time0 = W'(o0); period1 = W'(p1); on_time1 = W'(o1);
    @(negedge clk);
    en = 1'b1; k = 0;
  endtask

  task automatic step();
    @(posedge clk); k++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    en = 1'b0; indep_mode = 1'b1;
    period0 = 16'd3; on_time0 = 16'd9; period1 = 16'd3; on_time1 = 16'd9;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm0, 1'b0, "R1", "reset pwm0");
    chk(pwm1, 1'b0, "R1", "reset pwm1");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_indep(input int p0, input int o0, input int p1, input int o1,
                         input int n, input string req);
    start(p0, o0, p1, o1, 1'b1);
    for (int i = 0; i < n; i++) begin
      step();
      chk(pwm0, f_lin(k, p0, o0), req, "indep pwm0");
      chk(pwm1, f_lin(k, p1, o1), req, "indep pwm1");
    end
  endtask

  task automatic t_off(input int p0, input int o0, input int d, input int o1,
                       input int n, input string req);
    start(p0, o0, d, o1, 1'b0);
    for (int i = 0; i < n; i++) begin
      step();
      chk(pwm0, f_lin(k, p0, o0), req, "offset pwm0");
      chk(pwm1, f_off(k, p0, d, o1), req, "offset pwm1");
    end
  endtask

  // R8: mid-cycle writes wait for each channel's own boundary
  task automatic t_update();
    start(5, 2, 3, 3, 1'b1);
    for (int i = 0; i < 3; i++) step();
    period0 = 16'd2; on_time0 = 16'd1; period1 = 16'd6; on_time1 = 16'd5;
    for (int i = 0; i < 40; i++) begin
      step();
      chk(pwm0, (k < 12) ? f_lin(k, 5, 2) : f_lin(k - 12, 2, 1), "R8", "update pwm0");
      chk(pwm1, (k < 8)  ? f_lin(k, 3, 3) : f_lin(k - 8, 6, 5),  "R8", "update pwm1");
    end
  endtask

  // R9: mode captured at channel 0 boundary
  task automatic t_mode_switch();
    start(3, 2, 1, 1, 1'b1);
    for (int i = 0; i < 3; i++) step();
    indep_mode = 1'b0; period1 = 16'd2; on_time1 = 16'd1;
    for (int i = 0; i < 24; i++) begin
      step();
      chk(pwm0, f_lin(k, 3, 2), "R9", "switch pwm0");
      if (k < 4)
        chk(pwm1, f_lin(k, 1, 1), "R9", "switch pwm1 old");
      else if (k < 8)
        chk(pwm1, f_lin(k - 4, 2, 1), "R9", "switch pwm1 indep");
      else
        chk(pwm1, f_off(k - 8, 3, 2, 1), "R9", "switch pwm1 offset");
    end
  endtask

  task automatic t_disable();
    start(2, 5, 2, 5, 1'b1);
    for (int i = 0; i < 5; i++) step();
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(pwm0, 1'b0, "R1", "disabled pwm0");
      chk(pwm1, 1'b0, "R1", "disabled pwm1");
    end
    start(4, 2, 6, 3, 1'b1);
    for (int i = 0; i < 30; i++) begin
      step();
      chk(pwm0, f_lin(k, 4, 2), "R1", "restart pwm0");
      chk(pwm1, f_lin(k, 6, 3), "R1", "restart pwm1");
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; k = 0; done = 1'b0;
    t_reset();
    t_indep(5, 2, 3, 1, 48, "R2 R3");
    t_indep(4, 0, 2, 0, 30, "R4");
    t_indep(3, 4, 2, 9, 30, "R5");
    t_indep(0, 1, 7, 7, 40, "R5 R3");
    t_off(5, 3, 2, 2, 48, "R6 R9");
    t_off(6, 2, 0, 3, 42, "R6");
    t_off(4, 1, 9, 2, 40, "R7");
    t_update();
    t_mode_switch();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule